// File: doc/BRIEF.md
# Single-Level Page Translation Unit

This block maps virtual addresses to physical addresses for a client that issues one translation at a time. Each virtual address holds a virtual page number in its upper bits and a byte offset within the page in its lower bits. The page size is a power of two. A small fully associative translation cache holds recent page mappings. When a lookup hits in that cache, the answer comes back on the next clock.

On a miss, the unit computes where the page table entry lives in memory. That address is the table base register plus four times the virtual page number. The unit then issues a single read for the entry and waits for the data. If the entry marks the page as present, the physical address is the entry's frame number joined to the unchanged offset, and the mapping is cached. If the entry does not mark the page as present, the frame number is discarded and the response carries a fault instead.

Software loads the table base register through a one-cycle write strobe. Every such write empties the translation cache.

Top module: `page_xlate_unit`

## Requirements
- R1: While reset is held, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_req` is 0.
- R2: A request whose page number is cached produces `rsp_valid` on the clock after acceptance. That response carries `{cached frame, offset}` with `rsp_fault` low, and the unit issues no table read.
- R3: A request whose page number is not cached issues exactly one table read. The read address is `base + {page_number, 2'b00}`, where the page number is `req_vaddr[31:12]`.
- R4: In a table entry, bit 31 marks the page as present and bits 19:0 hold the frame number. For a present entry, the response is `rsp_paddr = {entry[19:0], req_vaddr[11:0]}` with `rsp_fault` low.
- R5: When entry bit 31 is 0, the response has `rsp_fault` = 1 and `rsp_paddr` = 0. The mapping is not cached, so a repeat request reads the table again.
- R6: Only one translation is outstanding. `req_ready` is low from the clock after a missing request is accepted until the table data returns.
- R7: The translation cache holds 8 mappings. They are filled in round-robin slot order, so the ninth distinct fill evicts the first mapping while the others stay cached.
- R8: A write to the base register invalidates every cached mapping.
- R9: A base write made while a table read is pending leaves that read's address unchanged. The walk's result is still returned, but it is not cached.
- R10: `mem_rd_req` stays high, with `mem_rd_addr` stable, until the cycle in which `mem_rd_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page not present |
| mem_rd_req | output | 1 | Table entry read request |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 32 | Table entry contents |
| base_wr_en | input | 1 | Base register write strobe |
| base_wr_data | input | 32 | New table base address |

## Verification
The bench builds the unit with its default values: 32-bit addresses, 4 KiB pages, 20-bit frames and an 8-slot cache. With these values a random pool of twelve page numbers overflows the cache, so evictions, refills and hits all occur under mixed traffic. The bench memory model returns entries after a random delay of zero to two cycles. A fixed longer delay is used when the base must be rewritten while a table read is still pending. The entry contents come from a hash of the address, so present and absent pages occur at a known ratio. Absent entries carry non-zero frame bits, which shows that those bits are discarded.

// File: rtl/pxu_pkg.sv
// Package: shared types of the page translation unit.
// Assumes: included ahead of every pxu_* module.
package pxu_pkg;
    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_WAIT = 1'b1
    } wk_state_e;
endpackage

// File: rtl/pxu_tlb.sv
// Module: pxu_tlb
// Fully associative translation cache with a combinational lookup.
// Fills go to slots in round-robin order. A flush clears all valid bits and
// wins over a fill in the same cycle.
// Assumes: the caller fills only page numbers that currently miss, so no
// page number is held twice.
module pxu_tlb #(
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             look_hit,
    output logic [PFN_W-1:0] look_pfn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [DEPTH-1:0] ent_v;
    logic [DEPTH-1:0] match;
    logic [VPN_W-1:0] ent_vpn [DEPTH];
    logic [PFN_W-1:0] ent_pfn [DEPTH];
    logic [IDX_W-1:0] fill_ptr;

    // one tag comparator per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = ent_v[g] && (ent_vpn[g] == look_vpn);
    end

    // OR-combine the frame of the matching slot
    always_comb begin
        look_pfn = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) look_pfn = look_pfn | ent_pfn[i];
        end
    end

    assign look_hit = |match;

    // valid bits and round-robin fill pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v    <= '0;
            fill_ptr <= '0;
        end else if (flush) begin
            ent_v <= '0;
        end else if (fill_en) begin
            ent_v[fill_ptr] <= 1'b1;
            fill_ptr        <= (fill_ptr == LAST_IDX) ? '0 : fill_ptr + 1'b1;
        end
    end

    // slot payload, written only on fill
    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            ent_vpn[fill_ptr] <= fill_vpn;
            ent_pfn[fill_ptr] <= fill_pfn;
        end
    end

    // R7
    tlb_single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R8
    tlb_flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !look_hit);
endmodule

// File: rtl/pxu_walker.sv
// Module: pxu_walker
// Accepts requests and answers hits directly. On a miss it reads the table
// entry and forms the response, then decides whether to fill the cache.
// Assumes: the tlb_hit/tlb_pfn inputs reflect req_vaddr in the same cycle,
// and the memory acknowledges each read with a single-cycle mem_rd_ack.
module pxu_walker
    import pxu_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PFN_W     = 20,
    parameter int PTE_W     = 32,
    parameter int AW        = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [VA_W-1:0]               req_vaddr,
    input  logic [AW-1:0]                 base_addr,
    input  logic                          base_wr_en,
    input  logic                          tlb_hit,
    input  logic [PFN_W-1:0]              tlb_pfn,
    output logic                          fill_en,
    output logic [VA_W-PAGE_BITS-1:0]     fill_vpn,
    output logic [PFN_W-1:0]              fill_pfn,
    output logic                          mem_rd_req,
    output logic [AW-1:0]                 mem_rd_addr,
    input  logic                          mem_rd_ack,
    input  logic [PTE_W-1:0]              mem_rd_data,
    output logic                          rsp_valid,
    output logic [PFN_W+PAGE_BITS-1:0]    rsp_paddr,
    output logic                          rsp_fault
);
    localparam int VPN_W = VA_W - PAGE_BITS;

    wk_state_e            state;
    logic [VPN_W-1:0]     pend_vpn;
    logic [PAGE_BITS-1:0] pend_off;
    logic                 stale;
    logic                 accept;
    logic                 walk_done;
    logic                 pte_present;
    logic [PFN_W-1:0]     pte_pfn;

    assign req_ready   = (state == WK_IDLE);
    assign accept      = req_valid && req_ready;
    assign mem_rd_req  = (state == WK_WAIT);
    assign walk_done   = (state == WK_WAIT) && mem_rd_ack;
    assign pte_present = mem_rd_data[PTE_W-1];
    assign pte_pfn     = mem_rd_data[PFN_W-1:0];

    assign fill_en  = walk_done && pte_present && !stale && !base_wr_en;
    assign fill_vpn = pend_vpn;
    assign fill_pfn = pte_pfn;

    // sequencer: leave idle on a miss, return when the entry arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WK_IDLE;
        end else if (accept && !tlb_hit) begin
            state <= WK_WAIT;
        end else if (walk_done) begin
            state <= WK_IDLE;
        end
    end

    // capture request fields and the entry address at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vpn    <= '0;
            pend_off    <= '0;
            mem_rd_addr <= '0;
        end else if (accept) begin
            pend_vpn    <= req_vaddr[VA_W-1:PAGE_BITS];
            pend_off    <= req_vaddr[PAGE_BITS-1:0];
            mem_rd_addr <= base_addr + (AW'(req_vaddr[VA_W-1:PAGE_BITS]) << 2);
        end
    end

    // mark the pending walk stale when the base moves under it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stale <= 1'b0;
        end else if (accept) begin
            stale <= 1'b0;
        end else if (base_wr_en && state == WK_WAIT) begin
            stale <= 1'b1;
        end
    end

    // response register for both hit and walk completions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= (accept && tlb_hit) || walk_done;
            rsp_fault <= walk_done && !pte_present;
            if (accept && tlb_hit) begin
                rsp_paddr <= {tlb_pfn, req_vaddr[PAGE_BITS-1:0]};
            end else if (walk_done) begin
                rsp_paddr <= pte_present ? {pte_pfn, pend_off} : '0;
            end
        end
    end

    // R2
    hit_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && tlb_hit) |=> (rsp_valid && !rsp_fault));

    // R6
    miss_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !tlb_hit) |=> (!req_ready && mem_rd_req && !rsp_valid));

    // R10
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));
endmodule

// File: rtl/page_xlate_unit.sv
// Module: page_xlate_unit (top)
// Translates virtual to physical addresses. It uses a translation cache and,
// on a miss, walks a one-level page table in memory.
// Assumes: one request in flight at a time, and a memory port that returns
// each entry with a single-cycle acknowledge.
module page_xlate_unit #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PFN_W     = 20,
    parameter int PTE_W     = 32,
    parameter int TLB_DEPTH = 8,
    parameter int AW        = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [VA_W-1:0]            req_vaddr,
    output logic                       rsp_valid,
    output logic [PFN_W+PAGE_BITS-1:0] rsp_paddr,
    output logic                       rsp_fault,
    output logic                       mem_rd_req,
    output logic [AW-1:0]              mem_rd_addr,
    input  logic                       mem_rd_ack,
    input  logic [PTE_W-1:0]           mem_rd_data,
    input  logic                       base_wr_en,
    input  logic [AW-1:0]              base_wr_data
);
    localparam int VPN_W = VA_W - PAGE_BITS;

    logic [AW-1:0]    base_q;
    logic             tlb_hit;
    logic [PFN_W-1:0] tlb_pfn;
    logic             fill_en;
    logic [VPN_W-1:0] fill_vpn;
    logic [PFN_W-1:0] fill_pfn;

    // table base register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (base_wr_en) begin
            base_q <= base_wr_data;
        end
    end

    pxu_tlb #(
        .VPN_W (VPN_W),
        .PFN_W (PFN_W),
        .DEPTH (TLB_DEPTH)
    ) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (base_wr_en),
        .look_vpn (req_vaddr[VA_W-1:PAGE_BITS]),
        .look_hit (tlb_hit),
        .look_pfn (tlb_pfn),
        .fill_en  (fill_en),
        .fill_vpn (fill_vpn),
        .fill_pfn (fill_pfn)
    );

    pxu_walker #(
        .VA_W      (VA_W),
        .PAGE_BITS (PAGE_BITS),
        .PFN_W     (PFN_W),
        .PTE_W     (PTE_W),
        .AW        (AW)
    ) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_vaddr   (req_vaddr),
        .base_addr   (base_q),
        .base_wr_en  (base_wr_en),
        .tlb_hit     (tlb_hit),
        .tlb_pfn     (tlb_pfn),
        .fill_en     (fill_en),
        .fill_vpn    (fill_vpn),
        .fill_pfn    (fill_pfn),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_ack  (mem_rd_ack),
        .mem_rd_data (mem_rd_data),
        .rsp_valid   (rsp_valid),
        .rsp_paddr   (rsp_paddr),
        .rsp_fault   (rsp_fault)
    );
endmodule

// File: tb/test_page_xlate_unit.sv
module test_page_xlate_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;

    always #10 clk = ~clk;

    page_xlate_unit i_page_xlate_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .base_wr_en(base_wr_en), .base_wr_data(base_wr_data)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    int rd_cnt = 0;
    int fixed_delay = -1;
    logic [31:0] exp_pte_addr = '0;

    // reference cache model
    bit          m_v [8];
    logic [19:0] m_vpn [8];
    logic [19:0] m_pfn [8];
    int          m_ptr = 0;
    logic [31:0] m_base = '0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pte_of(input logic [31:0] a);
        logic [31:0] h;
        h = a * 32'h9E37_79B1;
        h = h ^ (h >> 15);
        return {(h[5:4] != 2'b00), h[30:0]};
    endfunction

    function automatic bit present_at(input logic [31:0] b, input logic [19:0] vpn);
        logic [31:0] e;
        e = pte_of(b + {10'b0, vpn, 2'b00});
        return e[31];
    endfunction

    task automatic model_flush();
        for (int i = 0; i < 8; i++) m_v[i] = 0;
    endtask

    // memory responder with address and hold checks
    initial begin
        int waitc;
        logic [31:0] hold;
        waitc = -1;
        hold = '0;
        forever begin
            @(negedge clk);
            mem_rd_ack = 1'b0;
            if (mem_rd_req) begin
                if (waitc < 0) begin
                    waitc = (fixed_delay >= 0) ? fixed_delay : int'($urandom % 3);
                    hold = mem_rd_addr;
                    // R3 entry address
                    check(mem_rd_addr == exp_pte_addr, "R3 entry address", mem_rd_addr, exp_pte_addr);
                end else begin
                    // R10 address held
                    check(mem_rd_addr == hold, "R10 address stable", mem_rd_addr, hold);
                end
                if (waitc == 0) begin
                    mem_rd_ack = 1'b1;
                    mem_rd_data = pte_of(mem_rd_addr);
                    rd_cnt++;
                    waitc = -1;
                end else begin
                    waitc--;
                end
            end
        end
    end

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        base_wr_en = 1'b1;
        base_wr_data = b;
        @(negedge clk);
        base_wr_en = 1'b0;
        m_base = b;
        model_flush();
    endtask

    task automatic translate(input logic [31:0] va, input bit mid_base, input logic [31:0] nb, output bit did_read);
        logic [19:0] vpn;
        logic [31:0] pte;
        logic [31:0] expa;
        int hit_i;
        int lat;
        int rd0;
        bit stale;
        vpn = va[31:12];
        exp_pte_addr = m_base + {10'b0, vpn, 2'b00};
        hit_i = -1;
        for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == vpn) hit_i = i;
        rd0 = rd_cnt;
        stale = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 60) begin
            if (lat == 1) begin
                // R6 no second acceptance while walking
                check(!req_ready, "R6 ready low during walk", req_ready, 0);
            end
            if (mid_base && lat == 1) begin
                base_wr_en = 1'b1;
                base_wr_data = nb;
                stale = 1;
            end else begin
                base_wr_en = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        base_wr_en = 1'b0;
        if (stale) begin
            m_base = nb;
            model_flush();
        end
        did_read = (rd_cnt != rd0);
        if (hit_i >= 0) begin
            expa = {m_pfn[hit_i], va[11:0]};
            check(lat == 1, "R2 hit latency", lat, 1);
            check(!did_read, "R2 no table read on hit", rd_cnt - rd0, 0);
            check(rsp_valid && rsp_paddr == expa && !rsp_fault, "R2 hit address",
                  {rsp_fault, rsp_paddr}, {1'b0, expa});
        end else begin
            pte = pte_of(exp_pte_addr);
            check(rd_cnt == rd0 + 1, "R3 one read per miss", rd_cnt - rd0, 1);
            check(rsp_valid && lat >= 2, "R6 walk response", lat, 2);
            if (pte[31]) begin
                expa = {pte[19:0], va[11:0]};
                check(rsp_paddr == expa && !rsp_fault, "R4 present translation",
                      {rsp_fault, rsp_paddr}, {1'b0, expa});
                if (!stale) begin
                    m_v[m_ptr] = 1;
                    m_vpn[m_ptr] = vpn;
                    m_pfn[m_ptr] = pte[19:0];
                    m_ptr = (m_ptr + 1) % 8;
                end
            end else begin
                check(rsp_fault && rsp_paddr == 32'h0, "R5 fault response",
                      {rsp_fault, rsp_paddr}, {1'b1, 32'h0});
            end
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [19:0] pv [9];
        logic [19:0] fv;
        logic [19:0] sv;
        logic [19:0] pool [12];
        int n;
        bit rd;
        void'($urandom(32'd4711));
        for (int i = 0; i < 8; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 no response in reset", rsp_valid, 0);
        check(mem_rd_req == 1'b0, "R1 no read in reset", mem_rd_req, 0);
        rst_n = 1'b1;

        set_base(32'h0010_0000);
        n = 0;
        fv = '0;
        for (int v = 1; v < 600; v++) begin
            if (n < 9 && present_at(m_base, 20'(v))) begin
                pv[n] = 20'(v);
                n++;
            end
            if (fv == 0 && !present_at(m_base, 20'(v))) fv = 20'(v);
        end

        // R7 fill eight slots, then all hit
        for (int i = 0; i < 8; i++) begin
            translate({pv[i], 12'($urandom)}, 0, 0, rd);
            check(rd, "R7 first touch walks", rd, 1);
        end
        for (int i = 0; i < 8; i++) begin
            translate({pv[i], 12'($urandom)}, 0, 0, rd);
            check(!rd, "R7 eight mappings held", rd, 0);
        end
        translate({pv[8], 12'h0FF}, 0, 0, rd);
        translate({pv[0], 12'hABC}, 0, 0, rd);
        check(rd, "R7 oldest slot evicted", rd, 1);
        translate({pv[2], 12'h001}, 0, 0, rd);
        check(!rd, "R7 round robin keeps others", rd, 0);

        // R5 absent page is never cached
        translate({fv, 12'hFFF}, 0, 0, rd);
        translate({fv, 12'h000}, 0, 0, rd);
        check(rd, "R5 absent page walks again", rd, 1);

        // R8 base write flushes
        set_base(32'h0020_0000);
        translate({pv[2], 12'h010}, 0, 0, rd);
        check(rd, "R8 flush forces walk", rd, 1);

        // R9 base write during a pending read
        sv = '0;
        for (int v = 700; v < 1200; v++) begin
            if (sv == 0 && present_at(m_base, 20'(v))) sv = 20'(v);
        end
        fixed_delay = 4;
        translate({sv, 12'h123}, 1, 32'h0030_0000, rd);
        fixed_delay = -1;
        translate({sv, 12'h456}, 0, 0, rd);
        check(rd, "R9 stale walk not cached", rd, 1);

        // random traffic over a pool larger than the cache
        for (int j = 0; j < 12; j++) pool[j] = 20'h100 + 20'(j * 3);
        for (int k = 0; k < 400; k++) begin
            if ($urandom % 40 == 0) set_base(($urandom % 2 == 0) ? 32'h0010_0000 : 32'h0040_0000);
            translate({pool[$urandom % 12], 12'($urandom)}, 0, 0, rd);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule